// File: doc/BRIEF.md
# Clock-Synchronous Serial Transceiver

This block moves one 8-bit character at a time between a parallel host side and a three-wire synchronous serial link: a clock output, a data output and a data input. It is the clock master. A start strobe loads the transmit byte and starts a transfer. The block then divides the system clock to make the transfer clock, changes output data on one edge of that clock and samples input data on the other. When the eighth input bit has been captured, the received byte appears on the read port.

Three configuration inputs shape each transfer. Polarity picks the idle level of the clock and which clock edges drive and sample data. Bit order picks least or most significant bit first. Inversion complements the data in both directions. The block captures these inputs, together with the divider value, when it accepts a start strobe. It holds them fixed until the transfer ends.

Top module: `sync_serial_xcvr`

## Requirements
- R1: One transfer has exactly 8 driving edges and 8 sampling edges on `sclk`, 16 transitions in total, after which `sclk` is back at its idle level.
- R2: With `cfg_pol`=0, `sdo` changes on falling edges of `sclk`, `sdi` is sampled on rising edges, and `sclk` rests high when no transfer is in progress.
- R3: With `cfg_pol`=1, `sdo` changes on rising edges, `sdi` is sampled on falling edges, and `sclk` rests low when no transfer is in progress.
- R4: With `cfg_msb`=0, bits go out and come in in the order bit 0 to bit 7. With `cfg_msb`=1, the order is bit 7 to bit 0. `rx_byte` holds each received bit at the position it occupied in the sender's byte.
- R5: With `cfg_inv`=1, every bit on `sdo` is the complement of the transmit bit, and every received bit is the complement of the `sdi` level. With `cfg_inv`=0, data passes unchanged.
- R6: The first transition of `sclk` after a start is a driving edge, so the first data bit is on `sdo` before the first sampling edge.
- R7: `busy` rises in the cycle after a start strobe is accepted. On the clock edge that performs the eighth sampling, `busy` falls, `done` is high for exactly one cycle and `rx_byte` is loaded.
- R8: While `busy` is high, a start strobe and any change of `cfg_pol`, `cfg_msb`, `cfg_inv`, `div_val` or `tx_byte` has no effect on the transfer in progress.
- R9: Each half period of `sclk` during a transfer lasts `div_val`+1 system-clock cycles, so `div_val`=0 gives one cycle per half period.
- R10: After reset, `busy` and `done` are low, `sdo` is high, and `sclk` sits at the idle level of the current `cfg_pol`. It follows that input within one cycle while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start strobe, accepted only when idle |
| tx_byte | input | 8 | Byte to transmit |
| div_val | input | 8 | Half-period divider (half period = div_val+1 cycles) |
| cfg_pol | input | 1 | Clock polarity and edge select |
| cfg_msb | input | 1 | 1 = most significant bit first |
| cfg_inv | input | 1 | 1 = invert data both ways |
| sdi | input | 1 | Serial data in |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse when rx_byte is loaded |
| rx_byte | output | 8 | Last received byte |
| sclk | output | 1 | Transfer clock out |
| sdo | output | 1 | Serial data out |

## Verification
On every cycle, the assertions check the following: the shape of `done` and its relation to `busy`, the rise of `busy` after an accepted start, `sdo` idling high, `sclk` holding still between divider ticks, the idle level following polarity, and the captured configuration staying frozen. Only the bench scenarios can show the rest. These are the bit order and inversion on the wire, the recovered byte, and that drive edges fall on the edge polarity selects. They also cover the half-period length for each divider value and that a second start during a transfer leaves the result untouched.

// File: rtl/ser_xcvr_pkg.sv
package ser_xcvr_pkg;
  // Per-transfer settings captured at start
  typedef struct packed {
    logic pol;   // 0: idle high, drive on fall; 1: idle low, drive on rise
    logic msb;   // 1: most significant bit first
    logic inv;   // 1: complement data
  } ser_cfg_t;
endpackage

// File: rtl/ser_edge_gen.sv
module ser_edge_gen #(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 8
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        start_i,
  input  logic                        busy_i,
  input  logic                        pol_now_i,
  input  logic [DIV_W-1:0]            div_i,
  output logic                        drive_o,
  output logic                        sample_o,
  output logic                        last_o,
  output logic [$clog2(DATA_W)-1:0]   bit_idx_o,
  output logic                        sclk_o
);
  localparam int EDGE_W = $clog2(2*DATA_W);
  localparam logic [EDGE_W-1:0] LAST_EDGE = EDGE_W'(2*DATA_W-1);

  logic [DIV_W-1:0]  cnt_q;
  logic [EDGE_W-1:0] edge_q;
  logic              sclk_q;
  logic              tick;

  assign tick      = busy_i && (cnt_q == div_i);
  assign drive_o   = tick && !edge_q[0];
  assign sample_o  = tick &&  edge_q[0];
  assign last_o    = sample_o && (edge_q == LAST_EDGE);
  assign bit_idx_o = edge_q[EDGE_W-1:1];
  assign sclk_o    = sclk_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      edge_q <= '0;
      sclk_q <= ~pol_now_i;
    end else if (start_i) begin
      cnt_q  <= '0;
      edge_q <= '0;
      sclk_q <= ~pol_now_i;
    end else if (busy_i) begin
      if (tick) begin
        cnt_q  <= '0;
        edge_q <= edge_q + 1'b1;
        sclk_q <= ~sclk_q;
      end else begin
        cnt_q  <= cnt_q + 1'b1;
      end
    end else begin
      sclk_q <= ~pol_now_i;
    end
  end

  // R9: clock holds between divider ticks
  p_sclk_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (busy_i && !start_i && (cnt_q != div_i)) |=> $stable(sclk_q));

  // R10: while idle the clock follows the current polarity
  p_idle_level_r10: assert property (@(posedge clk) disable iff (rst)
    !busy_i |=> (sclk_q == !$past(pol_now_i)));
endmodule

// File: rtl/ser_shift_path.sv
module ser_shift_path
  import ser_xcvr_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        start_i,
  input  logic [DATA_W-1:0]           tx_i,
  input  ser_cfg_t                    cfg_i,
  input  logic                        drive_i,
  input  logic                        sample_i,
  input  logic                        last_i,
  input  logic [$clog2(DATA_W)-1:0]   bit_idx_i,
  input  logic                        sdi_i,
  output logic                        sdo_o,
  output logic [DATA_W-1:0]           rx_o
);
  localparam int IDX_W = $clog2(DATA_W);

  logic [DATA_W-1:0] tx_q;
  logic [DATA_W-1:0] rx_sr_q;
  logic [DATA_W-1:0] rx_next;
  logic [DATA_W-1:0] rx_q;
  logic              sdo_q;
  logic [IDX_W-1:0]  phys;
  logic              in_bit;

  assign phys   = cfg_i.msb ? IDX_W'(DATA_W-1) - bit_idx_i : bit_idx_i;
  assign in_bit = sdi_i ^ cfg_i.inv;

  for (genvar g = 0; g < DATA_W; g++) begin : g_rx_bit
    assign rx_next[g] = (phys == IDX_W'(g)) ? in_bit : rx_sr_q[g];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_q    <= '0;
      rx_sr_q <= '0;
      rx_q    <= '0;
      sdo_q   <= 1'b1;
    end else begin
      if (start_i) begin
        tx_q    <= tx_i;
        rx_sr_q <= '0;
      end
      if (drive_i)
        sdo_q <= tx_q[phys] ^ cfg_i.inv;
      if (sample_i)
        rx_sr_q <= rx_next;
      if (last_i) begin
        rx_q  <= rx_next;
        sdo_q <= 1'b1;
      end
    end
  end

  assign sdo_o = sdo_q;
  assign rx_o  = rx_q;

  // R4: the read port only changes at the end of a transfer
  p_rx_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !last_i |=> $stable(rx_q));
endmodule

// File: rtl/sync_serial_xcvr.sv
module sync_serial_xcvr
  import ser_xcvr_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [DATA_W-1:0] tx_byte,
  input  logic [DIV_W-1:0]  div_val,
  input  logic              cfg_pol,
  input  logic              cfg_msb,
  input  logic              cfg_inv,
  input  logic              sdi,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rx_byte,
  output logic              sclk,
  output logic              sdo
);
  localparam int IDX_W = $clog2(DATA_W);

  ser_cfg_t          cfg_q;
  logic [DIV_W-1:0]  div_q;
  logic              busy_q;
  logic              done_q;
  logic              start_acc;
  logic              drive;
  logic              sample;
  logic              last;
  logic [IDX_W-1:0]  bit_idx;

  assign start_acc = start && !busy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q  <= '0;
      div_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= last;
      if (start_acc) begin
        cfg_q  <= '{pol: cfg_pol, msb: cfg_msb, inv: cfg_inv};
        div_q  <= div_val;
        busy_q <= 1'b1;
      end else if (last) begin
        busy_q <= 1'b0;
      end
    end
  end

  ser_edge_gen #(.DATA_W(DATA_W), .DIV_W(DIV_W)) u_edge (
    .clk       (clk),
    .rst       (rst),
    .start_i   (start_acc),
    .busy_i    (busy_q),
    .pol_now_i (cfg_pol),
    .div_i     (div_q),
    .drive_o   (drive),
    .sample_o  (sample),
    .last_o    (last),
    .bit_idx_o (bit_idx),
    .sclk_o    (sclk)
  );

  ser_shift_path #(.DATA_W(DATA_W)) u_path (
    .clk       (clk),
    .rst       (rst),
    .start_i   (start_acc),
    .tx_i      (tx_byte),
    .cfg_i     (cfg_q),
    .drive_i   (drive),
    .sample_i  (sample),
    .last_i    (last),
    .bit_idx_i (bit_idx),
    .sdi_i     (sdi),
    .sdo_o     (sdo),
    .rx_o      (rx_byte)
  );

  assign busy = busy_q;
  assign done = done_q;

  // R7: done lasts one cycle and coincides with busy falling
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);
  p_done_idle_r7: assert property (@(posedge clk) disable iff (rst)
    done_q |-> !busy_q);
  p_start_busy_r7: assert property (@(posedge clk) disable iff (rst)
    (start && !busy_q) |=> busy_q);

  // R8: captured settings frozen during a transfer
  p_cfg_frozen_r8: assert property (@(posedge clk) disable iff (rst)
    (busy_q && !last) |=> ($stable(cfg_q) && $stable(div_q)));

  // R10: data line idles high
  p_sdo_idle_r10: assert property (@(posedge clk) disable iff (rst)
    !busy_q |-> sdo);
endmodule

// File: tb/tb_sync_serial_xcvr.sv
module tb_sync_serial_xcvr;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic [7:0] tx_byte = '0;
  logic [7:0] div_val = '0;
  logic       cfg_pol = 1'b0;
  logic       cfg_msb = 1'b0;
  logic       cfg_inv = 1'b0;
  logic       sdi = 1'b0;
  logic       busy, done, sclk, sdo;
  logic [7:0] rx_byte;

  int n_chk = 0;
  int n_bad = 0;
  bit wd_hit = 1'b0;

  always #5 clk = ~clk;

  sync_serial_xcvr dut (
    .clk(clk), .rst(rst), .start(start), .tx_byte(tx_byte), .div_val(div_val),
    .cfg_pol(cfg_pol), .cfg_msb(cfg_msb), .cfg_inv(cfg_inv), .sdi(sdi),
    .busy(busy), .done(done), .rx_byte(rx_byte), .sclk(sclk), .sdo(sdo)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // One transfer; the bench acts as the far end and checks the wire
  task automatic xfer(input bit pol, input bit msb, input bit inv,
                      input int div, input logic [7:0] tx, input logic [7:0] rx_pat,
                      input bit poke);
    int c = 0, edges = 0, h = div + 1;
    logic prev;
    bit fin = 1'b0;
    @(negedge clk);
    cfg_pol = pol; cfg_msb = msb; cfg_inv = inv;
    div_val = 8'(div); tx_byte = tx; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R7 busy after start", busy, 1);
    check("R6 sclk idle before first edge", sclk, !pol);
    prev = sclk;
    while (!fin && c < 4000) begin
      @(negedge clk);
      c++;
      if (poke && c == 3) begin
        start = 1'b1; cfg_pol = !pol; cfg_msb = !msb; cfg_inv = !inv;
        div_val = 8'(div + 3); tx_byte = ~tx;
      end else begin
        start = 1'b0;
      end
      if (sclk !== prev) begin
        int idx;
        edges++;
        idx = (edges - 1) / 2;
        check("R9 edge timing", c, edges * h);
        if (edges % 2 == 1) begin
          // drive edge: polarity 0 falling, polarity 1 rising
          check(pol ? "R3 drive on rising" : "R2 drive on falling", sclk, pol);
          check(inv ? "R5 inverted sdo" : "R4 sdo bit order", sdo,
                (msb ? tx[7-idx] : tx[idx]) ^ inv);
          sdi = (msb ? rx_pat[7-idx] : rx_pat[idx]) ^ inv;
        end else begin
          check(pol ? "R3 sample on falling" : "R2 sample on rising", sclk, !pol);
        end
        if (edges == 16) begin
          check("R7 done at last sample", done, 1);
          check("R7 busy clear", busy, 0);
          check(poke ? "R8 rx unaffected" : "R4 R5 rx byte", rx_byte, rx_pat);
          check("R1 idle after 16 edges", sclk, !pol);
          check("R10 sdo back high", sdo, 1);
          fin = 1'b1;
        end
        prev = sclk;
      end else begin
        if (done) check("R7 early done", 1, 0);
      end
    end
    if (!fin) check("R1 transfer completes", edges, 16);
    start = 1'b0;
    @(negedge clk);
    check("R7 done one cycle", done, 0);
    check("R1 no extra edge", busy, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R10 reset busy", busy, 0);
    check("R10 reset done", done, 0);
    check("R10 reset sdo", sdo, 1);
    check("R10 reset sclk pol0", sclk, 1);
    cfg_pol = 1'b1;
    @(negedge clk);
    check("R10 idle sclk pol1", sclk, 0);
    cfg_pol = 1'b0;
    @(negedge clk);
    check("R10 idle sclk pol0", sclk, 1);

    for (int d = 0; d < 3; d++) begin
      for (int m = 0; m < 8; m++) begin
        logic [7:0] t, r;
        t = 8'h1D ^ 8'(m * 37 + d * 91);
        r = {t[3:0], ~t[7:4]} ^ 8'(m * 11);
        xfer(m[2], m[1], m[0], (d == 2) ? 4 : d, t, r, 1'b0);
      end
    end
    xfer(1'b0, 1'b1, 1'b0, 2, 8'h81, 8'h7E, 1'b1);
    xfer(1'b1, 1'b0, 1'b1, 0, 8'hC3, 8'h5A, 1'b1);
    xfer(1'b0, 1'b0, 1'b0, 0, 8'h00, 8'hFF, 1'b0);
    xfer(1'b1, 1'b1, 1'b0, 1, 8'hFF, 8'h00, 1'b0);

    if (!wd_hit) begin
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    wd_hit = 1'b1;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule